// File: doc/BRIEF.md
# Multimode 16-bit Counter/Timer

This block is a 16-bit down counter with a 16-bit reload latch, a divide-by-8 prescaler that can be bypassed, and a 3-bit mode input that selects one of eight behaviours. The modes are: off, event counting, pulse-width measurement, retriggerable one-shot, one-shot interval, free-run interval, one-shot pulse and free-run pulse. A single timer pin is split into an input, an output and an output enable. The pin acts as the event or gate input in the counting and measuring modes. It acts as the pulse output in the two generator modes.

Software writes the reload latch one byte at a time through a small write port, and it reads the live count on `count_q`. Writing the upper byte copies the whole latch into the counter and starts the count. Each time the counter steps below zero it reloads from the latch and raises a one-cycle interrupt pulse for the interrupt logic.

Top module: `mm_timer`

## Requirements
- R1: After reset `count_q` is 0, `irq` is 0, `pin_out` is 0, and the latch is 0.
- R2: A write with `wr_addr`=0 sets only the low latch byte, and `count_q` does not change. A write with `wr_addr`=1 sets the high latch byte, loads `count_q` with {high byte, low byte} at that clock edge, starts the count and restarts the prescaler.
- R3: With `prescale_en`=0 the count clock ticks on every clock. With `prescale_en`=1 it ticks once every 8 clocks. The first tick falls on the 8th edge after an upper-byte write.
- R4: In mode 0 (off), `count_q` holds its value over time and across pin edges.
- R5: In mode 1 (event count), `count_q` decrements once per rising edge of `pin_in`, independent of the prescaler.
- R6: In mode 2 (pulse-width measurement), `count_q` decrements on each count tick only while `pin_in` is high, and holds while it is low.
- R7: In mode 3 (retriggerable one-shot), a rising edge on `pin_in` reloads `count_q` from the latch and restarts the count. The count stops after its first underflow.
- R8: In mode 4 (one-shot interval) with latch value L, the underflow comes L+1 ticks after the start. `count_q` then holds L and no further underflow occurs.
- R9: In mode 5 (free-run interval), `count_q` reloads L at each underflow and keeps counting, so underflows repeat every L+1 ticks.
- R10: In modes 6 and 7, `pin_oe` is 1. In all other modes it is 0. In mode 6 (one-shot pulse), `pin_out` goes to 1 on the start write and to 0 at the underflow.
- R11: In mode 7 (free-run pulse), `pin_out` inverts at every underflow.
- R12: An underflow happens when a decrement is due while `count_q` is 0. At that edge `count_q` takes the latch value and `irq` is 1 for that one cycle. `irq` goes back to 0 unless another underflow follows at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Latch byte write strobe |
| wr_addr | input | 1 | 0 selects the low latch byte, 1 selects the high byte (starts the count) |
| wr_data | input | 8 | Byte to write |
| mode | input | 3 | Behaviour select, 0 to 7 |
| prescale_en | input | 1 | 1 selects the divide-by-8 count clock |
| pin_in | input | 1 | Timer pin as seen from outside (event or gate input) |
| pin_out | output | 1 | Timer pin output value |
| pin_oe | output | 1 | Timer pin output enable |
| count_q | output | 16 | Live counter value |
| irq | output | 1 | One-cycle underflow interrupt pulse |

## Verification
The bench builds the timer with its default 8-bit byte width (a 16-bit counter) and a prescale factor of 8. It loads latch values from 0 to 6, which puts many underflows within a few hundred clocks. For the interval modes it sweeps every latch value in that range against both prescaler settings. It checks the exact number of clocks to each underflow against (L+1) times the divide factor, which covers both the one-shot stop and the free-run reload. The event, gate, retrigger and pulse-output modes are each driven with short hand-timed pin patterns whose step counts are computed in the bench.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [2:0] {
        MD_OFF        = 3'd0,
        MD_EVENT      = 3'd1,
        MD_WIDTH      = 3'd2,
        MD_RETRIG     = 3'd3,
        MD_ONCE_IVL   = 3'd4,
        MD_LOOP_IVL   = 3'd5,
        MD_ONCE_PULSE = 3'd6,
        MD_LOOP_PULSE = 3'd7
    } mmt_mode_e;

    function automatic logic mmt_stops_after_uf(mmt_mode_e m);
        return (m == MD_RETRIG) || (m == MD_ONCE_IVL) || (m == MD_ONCE_PULSE);
    endfunction

    function automatic logic mmt_drives_pin(mmt_mode_e m);
        return (m == MD_ONCE_PULSE) || (m == MD_LOOP_PULSE);
    endfunction

endpackage

// File: rtl/mmt_prescale.sv
module mmt_prescale #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (restart)            div_d = '0;
        else if (div_q == LAST) div_d = '0;
        else                    div_d = div_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = !en || (div_q == LAST);
endmodule

// File: rtl/mmt_pin_edge.sv
module mmt_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = pin;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = pin && !prev_q;
endmodule

// File: rtl/mm_timer.sv
module mm_timer #(
    parameter int DATA_W = 8,
    parameter int PRE_DIV = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [2:0]            mode,
    input  logic                  prescale_en,
    input  logic                  pin_in,
    output logic                  pin_out,
    output logic                  pin_oe,
    output logic [2*DATA_W-1:0]   count_q,
    output logic                  irq
);
    import mmt_pkg::*;

    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] latch;
        logic             run;
        logic             out;
        logic             irq;
    } tmr_st_t;

    tmr_st_t   st_d, st_q;
    mmt_mode_e md;
    logic      tick, rise, wr_hi, wr_lo, step;

    assign md    = mmt_mode_e'(mode);
    assign wr_hi = wr_en && wr_addr;
    assign wr_lo = wr_en && !wr_addr;

    mmt_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (prescale_en),
        .restart (wr_hi),
        .tick    (tick)
    );

    mmt_pin_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_in),
        .rise  (rise)
    );

    always_comb begin
        unique case (md)
            MD_OFF:   step = 1'b0;
            MD_EVENT: step = rise;
            MD_WIDTH: step = tick && pin_in;
            default:  step = st_q.run && tick;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_lo) begin
            st_d.latch[DATA_W-1:0] = wr_data;
        end
        if (wr_hi) begin
            st_d.latch[CNT_W-1:DATA_W] = wr_data;
            st_d.cnt = {wr_data, st_q.latch[DATA_W-1:0]};
            st_d.run = 1'b1;
            if (md == MD_ONCE_PULSE) st_d.out = 1'b1;
        end else if (md == MD_RETRIG && rise) begin
            st_d.cnt = st_q.latch;
            st_d.run = 1'b1;
        end else if (step) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.latch;
                st_d.irq = 1'b1;
                if (mmt_stops_after_uf(md)) st_d.run = 1'b0;
                if (md == MD_ONCE_PULSE)    st_d.out = 1'b0;
                if (md == MD_LOOP_PULSE)    st_d.out = !st_q.out;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_q = st_q.cnt;
    assign irq     = st_q.irq;
    assign pin_out = st_q.out;
    assign pin_oe  = mmt_drives_pin(md);
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_addr,
    input logic [2:0]    mode,
    input logic [CW-1:0] count_q,
    input logic          irq,
    input logic          pin_out
);
    localparam logic [CW-1:0] UNIT = {{(CW-1){1'b0}}, 1'b1};
    logic hi_wr;
    assign hi_wr = wr_en && wr_addr;

    // R12: an interrupt is only raised from a counter that stood at zero
    p_irq_from_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(count_q) == '0);

    // R4: mode off keeps the count still unless the start write reloads it
    p_off_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && !hi_wr) |=> $stable(count_q));

    // R8: outside reloads, the count only ever moves down by one
    p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(hi_wr) && $past(mode) != 3'd3 && !irq && count_q != $past(count_q))
            |-> count_q == $past(count_q) - UNIT);

    // R11: free-run pulse output inverts with every underflow
    p_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode == 3'd7 && $past(mode) == 3'd7) |-> pin_out != $past(pin_out));

    // R10: one-shot pulse output is low after its underflow
    p_pulse_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode) == 3'd6) |-> !pin_out);
endmodule

bind mm_timer mm_timer_chk #(.CW(2*DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .mode    (mode),
    .count_q (count_q),
    .irq     (irq),
    .pin_out (pin_out)
);

// File: tb/tb_mm_timer.sv
`timescale 1ns/1ps
module tb_mm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  mode = 3'd0;
    logic        prescale_en = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, irq;
    logic [15:0] count_q;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = !clk;

    mm_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .prescale_en(prescale_en),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .count_q(count_q), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic start(input logic [2:0] m, input logic pe, input logic [15:0] val);
        mode = m; prescale_en = pe;
        wr(1'b0, val[7:0]);
        wr(1'b1, val[15:8]);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            cyc(1);
            n++;
            if (irq) break;
        end
    endtask

    task automatic pulse_pin();
        pin_in = 1'b1; cyc(1);
        pin_in = 1'b0; cyc(1);
    endtask

    initial begin
        int n, dv, seen;
        logic prev;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 count", count_q, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);

        // R2 / R4: byte writes in mode off
        wr(1'b0, 8'h34);
        chk("R2 low write leaves count", count_q, 0);
        wr(1'b1, 8'h12);
        chk("R2 high write loads count", count_q, 16'h1234);
        cyc(20);
        pulse_pin(); pulse_pin();
        chk("R4 off holds", count_q, 16'h1234);

        // R8 / R9 / R3 / R12 / R10 sweep of interval modes
        for (int pe = 0; pe < 2; pe++) begin
            dv = pe ? 8 : 1;
            for (int L = 0; L <= 6; L++) begin
                start(3'd4, pe[0], 16'(L));
                chk("R10 oe low in interval", pin_oe, 0);
                wait_irq(n);
                chk("R8 R3 one-shot underflow delay", n, (L + 1) * dv);
                chk("R8 reload value", count_q, L);
                cyc(1);
                chk("R12 irq single cycle", irq, 0);
                seen = 0;
                for (int i = 0; i < 3 * (L + 1) * dv; i++) begin
                    cyc(1);
                    if (irq) seen++;
                end
                chk("R8 stopped no irq", seen, 0);
                chk("R8 stopped count", count_q, L);

                start(3'd5, pe[0], 16'(L));
                wait_irq(n);
                chk("R9 R3 first underflow", n, (L + 1) * dv);
                wait_irq(n);
                chk("R9 repeat period", n, (L + 1) * dv);
                chk("R9 reload value", count_q, L);
            end
        end

        // R5 event counting
        start(3'd1, 1'b1, 16'd4);
        cyc(5);
        chk("R5 no edge no step", count_q, 4);
        for (int k = 1; k <= 4; k++) begin
            pulse_pin();
            chk("R5 one step per edge", count_q, 4 - k);
        end
        pin_in = 1'b1; cyc(1);
        chk("R5 R12 underflow irq", irq, 1);
        chk("R5 reload", count_q, 4);
        pin_in = 1'b0; cyc(1);

        // R6 pulse width measurement
        start(3'd2, 1'b0, 16'd100);
        pin_in = 1'b1; cyc(7);
        pin_in = 1'b0;
        chk("R6 counts while high", count_q, 93);
        cyc(5);
        chk("R6 holds while low", count_q, 93);
        start(3'd2, 1'b1, 16'd100);
        pin_in = 1'b1; cyc(24);
        pin_in = 1'b0;
        chk("R6 R3 prescaled width", count_q, 97);

        // R7 retriggerable one-shot
        start(3'd3, 1'b0, 16'd5);
        cyc(3);
        chk("R7 counting", count_q, 2);
        pin_in = 1'b1; cyc(1);
        chk("R7 retrigger reload", count_q, 5);
        wait_irq(n);
        chk("R7 underflow after retrigger", n, 6);
        cyc(20);
        chk("R7 stops after underflow", count_q, 5);
        pin_in = 1'b0; cyc(1);

        // R10 one-shot pulse
        start(3'd6, 1'b0, 16'd3);
        chk("R10 oe high", pin_oe, 1);
        chk("R10 out high at start", pin_out, 1);
        wait_irq(n);
        chk("R10 pulse length", n, 4);
        chk("R10 out low at underflow", pin_out, 0);
        cyc(10);
        chk("R10 out stays low", pin_out, 0);

        // R11 free-run pulse
        start(3'd7, 1'b0, 16'd2);
        chk("R11 oe high", pin_oe, 1);
        for (int t = 0; t < 4; t++) begin
            prev = pin_out;
            wait_irq(n);
            chk("R11 period", n, 3);
            chk("R11 toggle", pin_out, !prev);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule